// File: doc/BRIEF.md
# Word-Serial Montgomery Modular Multiplier

This block computes the Montgomery product of two multiprecision operands: given x and y below an odd modulus p, it returns x·y·R⁻¹ mod p with R = 2^(W·N). Operands are held as N limbs of W bits. One limb multiplier serves the whole operation. Each pass over a limb of y first adds the partial product x·y[i] into an accumulator of N+2 limbs. It then derives a quotient limb from the accumulator's low limb and the constant mu = −p⁻¹ mod 2^W. Adding quotient·p clears the low limb, so the accumulator shifts down by one limb. The caller supplies p and mu with every request.

After all N passes the raw value is below 2p. In full mode a single conditional subtraction of p brings it into [0, p). In lazy mode the raw value is returned as it is, for callers that reduce later. Inputs and outputs stay in Montgomery form, so a result can be fed straight back as an operand.

Operands enter through a valid/ready handshake. `in_ready` is high only while the block is idle, and the caller holds its request until it is accepted. The output side has no back-pressure. `out_valid` pulses for one cycle, and `result` then holds its value until the next request is accepted. A caller that cannot take the result at once simply reads the held value later.

Top module: `mont_cios_mul`

## Requirements
- R1: With `lazy_reduce` = 0 at acceptance, `result` equals x·y·2^(−W·N) mod p and is strictly below p, for any odd p and any x, y below p.
- R2: With `lazy_reduce` = 1 at acceptance, `result` is the unreduced value (x·y + m·p)/R, where m is the unique value in [0, R) with x·y + m·p ≡ 0 mod R. This value is below 2p and congruent mod p to the full-mode result. Bit W·N of `result` can be 1 only in this mode.
- R3: `in_ready` is 1 exactly while the block is idle. A request is taken only on a clock edge where `in_valid` and `in_ready` are both 1, and `in_ready` is 0 in the cycle after that edge.
- R4: `out_valid` is high for exactly one cycle per accepted request.
- R5: `out_valid` goes high exactly N·(2N+3)+1 clock edges after the accepting edge, which is 153 edges for W = 32 and N = 8.
- R6: `result` changes only on the edge that raises `out_valid` and otherwise holds its value.
- R7: After reset, `in_ready` = 1, `out_valid` = 0 and `result` = 0.
- R8: Changes on `op_x`, `op_y`, `modulus`, `mu` and `lazy_reduce` while the block is busy have no effect on the result in progress. A high `in_valid` while busy starts nothing.
- R9: A full-mode result used again as an operand gives the correct Montgomery product, so products can be chained.
- R10: A zero operand gives 0. Operands 1 and p−1 give the values R1 defines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Block idle, request can be taken |
| lazy_reduce | input | 1 | 1 skips the final subtraction |
| op_x | input | W·N | Operand x, below p |
| op_y | input | W·N | Operand y, below p |
| modulus | input | W·N | Odd modulus p |
| mu | input | W | −p⁻¹ mod 2^W |
| out_valid | output | 1 | One-cycle result strobe |
| result | output | W·N+1 | Montgomery product, held until next acceptance |

## Verification
The assertions watch the handshake on every cycle: the busy drop after acceptance, the single-cycle strobe, the fixed latency measured with a checker counter, the hold of `result` between strobes, and the range bound of each mode (below p in full mode, below 2p in lazy mode). Whether the value is actually the right product can only be shown by the bench scenarios. These compare results against a bit-serial reduction model over random and edge operands, over chained products, and over operand changes made while the block is busy.

// File: rtl/mont_pkg.sv
package mont_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_MUL,
    ST_MUL_TOP,
    ST_QUOT,
    ST_RED,
    ST_RED_TOP,
    ST_DONE
  } mont_state_e;
endpackage

// File: rtl/mont_limb_mac.sv
// One limb multiply-accumulate: a*b + c + d never overflows 2W bits.
module mont_limb_mac #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] c,
  input  logic [W-1:0] d,
  output logic [W-1:0] lo,
  output logic [W-1:0] hi
);
  localparam int PW = 2 * W;
  logic [PW-1:0] full;

  always_comb begin
    full = PW'(a) * PW'(b) + PW'(c) + PW'(d);
    lo   = full[W-1:0];
    hi   = full[PW-1:W];
  end
endmodule

// File: rtl/mont_seq_ctrl.sv
// Limb scheduler: per outer step, N multiply slots, a top fold, a quotient
// slot, N reduce slots and a shift fold; then one finishing slot.
module mont_seq_ctrl
  import mont_pkg::*;
#(
  parameter int N  = 8,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  output mont_state_e state,
  output logic [IW-1:0] outer_idx,
  output logic [IW-1:0] limb_idx
);
  localparam logic [IW-1:0] LAST = IW'(N - 1);

  mont_state_e st_q;
  logic [IW-1:0] i_q, j_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
      i_q  <= '0;
      j_q  <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (start) begin
          st_q <= ST_MUL;
          i_q  <= '0;
          j_q  <= '0;
        end
        ST_MUL: begin
          if (j_q == LAST) begin
            st_q <= ST_MUL_TOP;
            j_q  <= '0;
          end else begin
            j_q <= j_q + 1'b1;
          end
        end
        ST_MUL_TOP: st_q <= ST_QUOT;
        ST_QUOT: begin
          st_q <= ST_RED;
          j_q  <= '0;
        end
        ST_RED: begin
          if (j_q == LAST) begin
            st_q <= ST_RED_TOP;
            j_q  <= '0;
          end else begin
            j_q <= j_q + 1'b1;
          end
        end
        ST_RED_TOP: begin
          if (i_q == LAST) begin
            st_q <= ST_DONE;
          end else begin
            i_q  <= i_q + 1'b1;
            st_q <= ST_MUL;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign state     = st_q;
  assign outer_idx = i_q;
  assign limb_idx  = j_q;
endmodule

// File: rtl/mont_final_sub.sv
// Final correction: subtract p once when raw >= p, unless lazy mode.
module mont_final_sub #(
  parameter int WN = 256
) (
  input  logic [WN:0]   raw,
  input  logic [WN-1:0] modv,
  input  logic          lazy,
  output logic [WN:0]   res
);
  logic [WN+1:0] diff;
  logic          no_borrow;

  always_comb begin
    diff      = {1'b0, raw} - {2'b00, modv};
    no_borrow = ~diff[WN+1];
    res       = (no_borrow && !lazy) ? diff[WN:0] : raw;
  end
endmodule

// File: rtl/mont_cios_mul.sv
module mont_cios_mul
  import mont_pkg::*;
#(
  parameter int W = 32,
  parameter int N = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             lazy_reduce,
  input  logic [W*N-1:0]   op_x,
  input  logic [W*N-1:0]   op_y,
  input  logic [W*N-1:0]   modulus,
  input  logic [W-1:0]     mu,
  output logic             out_valid,
  output logic [W*N:0]     result
);
  localparam int WN = W * N;
  localparam int AL = N + 2;
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  mont_state_e   state;
  logic [IW-1:0] i_idx, j_idx;
  logic          accept;

  logic [WN-1:0] x_q, y_q, p_q;
  logic [W-1:0]  mu_q, m_q, carry_q;
  logic          lazy_q;
  logic [W-1:0]  acc_q [AL];

  logic [W-1:0]  mac_a, mac_b, mac_c, mac_d, mac_lo, mac_hi;
  logic [W:0]    top_sum;
  logic [WN:0]   raw_val, fin_res, result_q;
  logic          out_valid_q;

  assign accept   = in_valid && (state == ST_IDLE);
  assign in_ready = (state == ST_IDLE);

  mont_seq_ctrl #(.N(N), .IW(IW)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (accept),
    .state     (state),
    .outer_idx (i_idx),
    .limb_idx  (j_idx)
  );

  // Operand steering for the single limb multiplier.
  always_comb begin
    mac_a = '0;
    mac_b = '0;
    mac_c = '0;
    mac_d = '0;
    case (state)
      ST_MUL: begin
        mac_a = x_q[j_idx*W +: W];
        mac_b = y_q[i_idx*W +: W];
        mac_c = acc_q[j_idx];
        mac_d = (j_idx == '0) ? '0 : carry_q;
      end
      ST_QUOT: begin
        mac_a = acc_q[0];
        mac_b = mu_q;
      end
      ST_RED: begin
        mac_a = m_q;
        mac_b = p_q[j_idx*W +: W];
        mac_c = acc_q[j_idx];
        mac_d = (j_idx == '0) ? '0 : carry_q;
      end
      default: ;
    endcase
  end

  mont_limb_mac #(.W(W)) u_mac (
    .a  (mac_a),
    .b  (mac_b),
    .c  (mac_c),
    .d  (mac_d),
    .lo (mac_lo),
    .hi (mac_hi)
  );

  assign top_sum = {1'b0, acc_q[N]} + {1'b0, carry_q};

  always_comb begin
    raw_val = '0;
    for (int k = 0; k < N; k++) raw_val[k*W +: W] = acc_q[k];
    raw_val[WN] = acc_q[N][0];
  end

  mont_final_sub #(.WN(WN)) u_fin (
    .raw  (raw_val),
    .modv (p_q),
    .lazy (lazy_q),
    .res  (fin_res)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q         <= '0;
      y_q         <= '0;
      p_q         <= '0;
      mu_q        <= '0;
      m_q         <= '0;
      carry_q     <= '0;
      lazy_q      <= 1'b0;
      result_q    <= '0;
      out_valid_q <= 1'b0;
      for (int k = 0; k < AL; k++) acc_q[k] <= '0;
    end else begin
      out_valid_q <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            x_q     <= op_x;
            y_q     <= op_y;
            p_q     <= modulus;
            mu_q    <= mu;
            lazy_q  <= lazy_reduce;
            carry_q <= '0;
            for (int k = 0; k < AL; k++) acc_q[k] <= '0;
          end
        end
        ST_MUL: begin
          acc_q[j_idx] <= mac_lo;
          carry_q      <= mac_hi;
        end
        ST_MUL_TOP: begin
          acc_q[N]   <= top_sum[W-1:0];
          acc_q[N+1] <= {{(W-1){1'b0}}, top_sum[W]};
        end
        ST_QUOT: m_q <= mac_lo;
        ST_RED: begin
          carry_q <= mac_hi;
          if (j_idx != '0) acc_q[j_idx - 1'b1] <= mac_lo;
        end
        ST_RED_TOP: begin
          acc_q[N-1] <= top_sum[W-1:0];
          acc_q[N]   <= acc_q[N+1] + {{(W-1){1'b0}}, top_sum[W]};
          acc_q[N+1] <= '0;
        end
        ST_DONE: begin
          result_q    <= fin_res;
          out_valid_q <= 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign out_valid = out_valid_q;
  assign result    = result_q;
endmodule

// File: rtl/mont_cios_mul_chk.sv
module mont_cios_mul_chk #(
  parameter int W = 32,
  parameter int N = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           in_valid,
  input logic           in_ready,
  input logic           lazy_reduce,
  input logic [W*N-1:0] modulus,
  input logic           out_valid,
  input logic [W*N:0]   result
);
  localparam int LAT = N * (2 * N + 3) + 1;

  int unsigned    lat_cnt;
  logic           busy;
  logic           lazy_cap;
  logic [W*N-1:0] mod_cap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_cnt  <= 0;
      busy     <= 1'b0;
      lazy_cap <= 1'b0;
      mod_cap  <= '0;
    end else if (in_valid && in_ready) begin
      lat_cnt  <= 0;
      busy     <= 1'b1;
      lazy_cap <= lazy_reduce;
      mod_cap  <= modulus;
    end else if (out_valid) begin
      busy <= 1'b0;
    end else if (busy) begin
      lat_cnt <= lat_cnt + 1;
    end
  end

  p_busy_after_accept_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  p_single_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  p_fixed_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (busy && lat_cnt == LAT));

  p_result_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(result));

  p_full_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !lazy_cap) |-> (result < {1'b0, mod_cap}));

  p_lazy_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && lazy_cap) |-> (result < {mod_cap, 1'b0}));
endmodule

bind mont_cios_mul mont_cios_mul_chk #(.W(W), .N(N)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .lazy_reduce (lazy_reduce),
  .modulus     (modulus),
  .out_valid   (out_valid),
  .result      (result)
);

// File: tb/mont_cios_mul_bench.sv
`timescale 1ns/1ps
module mont_cios_mul_bench;
  localparam int W   = 32;
  localparam int N   = 8;
  localparam int WN  = W * N;
  localparam int LAT = N * (2 * N + 3) + 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          lazy_reduce = 1'b0;
  logic [WN-1:0] op_x = '0, op_y = '0, modulus = '0;
  logic [W-1:0]  mu = '0;
  logic          in_ready, out_valid;
  logic [WN:0]   result;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  mont_cios_mul #(.W(W), .N(N)) u_mont_cios_mul (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .lazy_reduce(lazy_reduce), .op_x(op_x), .op_y(op_y), .modulus(modulus),
    .mu(mu), .out_valid(out_valid), .result(result)
  );

  task automatic check(input bit ok, input string req, input logic [WN:0] act,
                       input logic [WN:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] calc_mu(input logic [WN-1:0] p);
    logic [W-1:0] inv = 1;
    for (int k = 0; k < 6; k++) inv = inv * (2 - p[W-1:0] * inv);
    return -inv;
  endfunction

  // Bit-serial reduction model: divide by 2 once per radix bit.
  function automatic logic [WN:0] ref_mont(input logic [WN-1:0] x, y, p, input bit lazy);
    logic [2*WN+1:0] t;
    t = (2*WN+2)'(x) * (2*WN+2)'(y);
    for (int k = 0; k < WN; k++) begin
      if (t[0]) t = t + (2*WN+2)'(p);
      t = t >> 1;
    end
    if (!lazy && t >= (2*WN+2)'(p)) t = t - (2*WN+2)'(p);
    return t[WN:0];
  endfunction

  function automatic logic [WN-1:0] rand_wide();
    logic [WN-1:0] v;
    for (int k = 0; k < N; k++) v[k*W +: W] = $urandom;
    return v;
  endfunction

  task automatic run_op(input logic [WN-1:0] x, y, p, input bit lazy, input bit disturb,
                        output logic [WN:0] res);
    int cnt;
    @(negedge clk);
    op_x = x; op_y = y; modulus = p; mu = calc_mu(p); lazy_reduce = lazy;
    in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check(in_ready == 1'b0, "R3 busy after accept", {{WN{1'b0}}, in_ready}, '0);
    if (disturb) begin
      op_x = rand_wide(); op_y = rand_wide(); modulus = rand_wide() | 1;
      mu = ~mu; lazy_reduce = ~lazy;
      repeat (3) @(negedge clk);
    end
    in_valid = 1'b0;
    cnt = 0;
    if (disturb) cnt = 3;
    forever begin
      @(posedge clk);
      cnt++;
      @(negedge clk);
      if (out_valid || cnt > LAT + 20) break;
    end
    check(cnt == LAT, "R5 latency", (WN+1)'(cnt), (WN+1)'(LAT));
    res = result;
    @(negedge clk);
    check(out_valid == 1'b0, "R4 single strobe", {{WN{1'b0}}, out_valid}, '0);
    check(in_ready == 1'b1, "R3 idle after done", {{WN{1'b0}}, in_ready}, 1);
  endtask

  task automatic op_check(input logic [WN-1:0] x, y, p, input bit lazy, input string req,
                          output logic [WN:0] res);
    logic [WN:0] exp;
    exp = ref_mont(x, y, p, lazy);
    run_op(x, y, p, lazy, 1'b0, res);
    check(res == exp, req, res, exp);
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [WN-1:0] p1, p2, xa, ya, za;
    logic [WN:0]   r, rf, exp;
    void'($urandom(32'h5eed_0042));
    p1 = {1'b1, 223'h0, 32'hFFFF_FFED} ; p1 = p1 | {8{32'h0000_1000}} | 1;
    p2 = rand_wide() | {1'b1, {(WN-1){1'b0}}} | 1;

    repeat (3) @(negedge clk);
    check(in_ready == 1'b1, "R7 reset ready", {{WN{1'b0}}, in_ready}, 1);
    check(out_valid == 1'b0, "R7 reset strobe", {{WN{1'b0}}, out_valid}, 0);
    check(result == '0, "R7 reset result", result, '0);
    rst_n = 1'b1;

    // R10 edge operands
    op_check('0, p1 - 1, p1, 1'b0, "R10 zero operand", r);
    check(r == '0, "R10 zero gives zero", r, '0);
    op_check(1, 1, p1, 1'b0, "R10 one times one", r);
    op_check(p1 - 1, p1 - 1, p1, 1'b0, "R10 p-1 squared", r);
    op_check(p2 - 1, 1, p2, 1'b0, "R10 p-1 times one", r);
    op_check(p2 - 1, p2 - 1, p2, 1'b1, "R2 lazy p-1 squared", r);

    // R6 hold after strobe
    repeat (5) @(negedge clk);
    exp = ref_mont(p2 - 1, p2 - 1, p2, 1'b1);
    check(result == exp, "R6 result held", result, exp);

    // R8 busy-time input changes ignored
    xa = rand_wide() % p1; ya = rand_wide() % p1;
    exp = ref_mont(xa, ya, p1, 1'b0);
    run_op(xa, ya, p1, 1'b0, 1'b1, r);
    check(r == exp, "R8 inputs ignored while busy", r, exp);

    // R9 chained products
    xa = rand_wide() % p2; ya = rand_wide() % p2;
    for (int k = 0; k < 4; k++) begin
      op_check(xa, ya, p2, 1'b0, "R9 chained product", r);
      za = r[WN-1:0];
      xa = ya; ya = za;
    end

    // R1/R2 random mix
    for (int k = 0; k < 24; k++) begin
      logic [WN-1:0] p;
      bit lz;
      p  = (k % 3 == 0) ? p1 : ((k % 3 == 1) ? p2 : (rand_wide() | 1));
      xa = rand_wide() % p; ya = rand_wide() % p;
      lz = k[0];
      if (lz) begin
        op_check(xa, ya, p, 1'b1, "R2 lazy raw value", r);
        rf = ref_mont(xa, ya, p, 1'b0);
        check(r < {p, 1'b0}, "R2 lazy below 2p", r, {p, 1'b0});
        check((r == rf) || (r == rf + (WN+1)'(p)), "R2 lazy congruent", r, rf);
      end else begin
        op_check(xa, ya, p, 1'b0, "R1 full product", r);
        check(r < {1'b0, p}, "R1 below p", r, {1'b0, p});
      end
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule